// File: doc/BRIEF.md
# Reference-Compare Up-Counting Timer

This block is a 16-bit up-counter driven from the system clock through an 8-bit programmable divider. Software reaches four registers over a small synchronous register bus: a mode word, a compare value, the live count and an event word. When a divided tick arrives while the count equals the compare value, the block latches an event flag. It can also drop the count back to zero, which makes it a periodic interrupt source.

The mode word holds five things. Bit 0 is the enable. Bits 2:1 choose the clock source, and only the system clock source is counted. Bit 3 makes the count restart on a match. Bit 4 enables the interrupt. The upper byte sets the divider. The interrupt line is the AND of the interrupt enable and the latched event flag, so software acknowledges an interrupt by writing one to the flag.

Top module: `refcmp_timer`

## Requirements
- R1: After reset, all four registers read as zero and `irq_o` is low.
- R2: While running, the count advances once every (mode[15:8] + 1) clock cycles, so the divide ratio runs from 1 to 256.
- R3: The count advances only when mode[2:1] is 01. The values 00, 10 and 11 hold the count and the divider still.
- R4: While mode[0] is 0, the count does not advance.
- R5: A mode write that moves mode[0] from 1 to 0 sets the count to zero and clears the event flag.
- R6: On a count step taken while the count equals the compare register, event bit 0 is set. If mode[3] is 1, the count then becomes zero. Otherwise it increments, and 0xFFFF rolls over to 0.
- R7: `irq_o` is high exactly when mode[4] is 1 and the event flag is 1.
- R8: Register addresses are 0 for mode, 1 for compare, 2 for count and 3 for event. A count write loads the written value. A count read returns the live count. Event reads return the flag in bit 0 and zeros in the other bits.
- R9: Writing event bit 0 as 1 clears the flag, and writing it as 0 leaves the flag as it was. If a clear and a match fall in the same cycle, the flag stays set.
- R10: A write to mode or compare restarts the divider phase and takes no count step in that cycle. The next step comes (mode[15:8] + 1) cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The assertions assume three things: the bus makes at most one access per cycle, `bus_we` and `bus_addr` are never unknown outside reset, and writes change only at the bus strobe. Under those assumptions, a count register that is not loaded or cleared moves only on a divider tick. The bench drives every bus input with defined values on the falling clock edge, one access per cycle. It biases the random divider and compare values towards small numbers so that matches, restarts, rollovers and clear/match collisions occur often.

// File: rtl/refcmp_timer_pkg.sv
package refcmp_timer_pkg;
  localparam int REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_MODE = 2'd0,
    REG_CMP  = 2'd1,
    REG_CNT  = 2'd2,
    REG_EVT  = 2'd3
  } reg_sel_e;

  localparam int MODE_EN_BIT    = 0;
  localparam int MODE_SRC_LO    = 1;
  localparam int MODE_RESTART   = 3;
  localparam int MODE_IRQEN     = 4;
  localparam int MODE_PSC_LO    = 8;
  localparam logic [1:0] SRC_SYSCLK = 2'b01;
endpackage

// File: rtl/rct_prescaler.sv
module rct_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PSC_W-1:0] div_i,
  output logic             tick_o
);
  generate
    if (PSC_W == 0) begin : g_nodiv
      assign tick_o = run_i && !restart_i;
    end else begin : g_div
      logic [PSC_W-1:0] phase_q, phase_d;
      logic             at_end;

      assign at_end = (phase_q == div_i);
      assign tick_o = run_i && !restart_i && at_end;

      always_comb begin
        if (!run_i || restart_i || at_end) phase_d = '0;
        else                               phase_d = phase_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
      end

      // R2: with a divisor above one, ticks never come back to back
      a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && (div_i != '0)) |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/rct_counter.sv
module rct_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             clr_i,
  input  logic             restart_en_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign match_o = step_i && (cnt_q == cmp_i);
  assign cnt_en  = clr_i || load_i || step_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                        cnt_d = '0;
    else if (load_i)                  cnt_d = load_val_i;
    else if (match_o && restart_en_i) cnt_d = '0;
    else if (step_i)                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R3/R4: without a step, load or clear the count holds
  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i && !clr_i) |=> $stable(cnt_q));

  // R6: a match with restart enabled lands on zero
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && restart_en_i && !clr_i && !load_i) |=> (cnt_q == '0));
endmodule

// File: rtl/rct_event.sv
module rct_event (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic w1c_i,
  input  logic hard_clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (hard_clr_i) flag_d = 1'b0;
    else if (set_i) flag_d = 1'b1;
    else if (w1c_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R9: a match beats a software clear in the same cycle
  a_r9_match_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !hard_clr_i) |=> flag_q);
endmodule

// File: rtl/refcmp_timer.sv
module refcmp_timer
  import refcmp_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              irq_o
);
  localparam int MODE_W = MODE_PSC_LO + PSC_W;
  localparam int DATA_W = 16;

  logic [MODE_W-1:0] mode_q, mode_d;
  logic [CNT_W-1:0]  cmp_q, cmp_d;
  logic [CNT_W-1:0]  cnt;
  logic              wr_mode, wr_cmp, wr_cnt, wr_evt;
  logic              cfg_wr, en_fall, run, tick, match, flag;

  assign wr_mode = bus_we && (bus_addr == REG_MODE);
  assign wr_cmp  = bus_we && (bus_addr == REG_CMP);
  assign wr_cnt  = bus_we && (bus_addr == REG_CNT);
  assign wr_evt  = bus_we && (bus_addr == REG_EVT);
  assign cfg_wr  = wr_mode || wr_cmp;
  assign en_fall = wr_mode && mode_q[MODE_EN_BIT] && !bus_wdata[MODE_EN_BIT];
  assign run     = mode_q[MODE_EN_BIT] &&
                   (mode_q[MODE_SRC_LO+1:MODE_SRC_LO] == SRC_SYSCLK);

  always_comb begin
    mode_d = wr_mode ? bus_wdata[MODE_W-1:0] : mode_q;
    cmp_d  = wr_cmp  ? bus_wdata[CNT_W-1:0]  : cmp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (wr_mode) mode_q <= mode_d;
      if (wr_cmp)  cmp_q  <= cmp_d;
    end
  end

  rct_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .restart_i (cfg_wr),
    .div_i     (mode_q[MODE_W-1:MODE_PSC_LO]),
    .tick_o    (tick)
  );

  rct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_i       (tick),
    .load_i       (wr_cnt),
    .load_val_i   (bus_wdata[CNT_W-1:0]),
    .clr_i        (en_fall),
    .restart_en_i (mode_q[MODE_RESTART]),
    .cmp_i        (cmp_q),
    .cnt_o        (cnt),
    .match_o      (match)
  );

  rct_event u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (match),
    .w1c_i      (wr_evt && bus_wdata[0]),
    .hard_clr_i (en_fall),
    .flag_o     (flag)
  );

  assign irq_o = mode_q[MODE_IRQEN] && flag;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_MODE: bus_rdata = DATA_W'(mode_q);
      REG_CMP:  bus_rdata = DATA_W'(cmp_q);
      REG_CNT:  bus_rdata = DATA_W'(cnt);
      default:  bus_rdata = DATA_W'(flag);
    endcase
  end

  // R5: disabling leaves both the count and the flag cleared
  a_r5_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_q[MODE_EN_BIT]) |-> ((cnt == '0) && !flag));

  // R10: a configuration write takes no count step
  a_r10_cfg_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !en_fall) |=> (cnt == $past(cnt)));

  // R8: a count write is visible on the next cycle
  a_r8_load_visible: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt == $past(bus_wdata[CNT_W-1:0])));
endmodule

// File: tb/refcmp_timer_tb.sv
`timescale 1ns/100ps
module refcmp_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [15:0] m_mode, m_cmp, m_cnt;
  logic [7:0]  m_pre;
  logic        m_evt;

  always #2.5 clk = ~clk;

  refcmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic [15:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_mode;
      2'd1:    return m_cmp;
      2'd2:    return m_cnt;
      default: return {15'd0, m_evt};
    endcase
  endfunction

  function automatic logic model_run();
    return m_mode[0] && (m_mode[2:1] == 2'b01);
  endfunction

  function automatic logic match_if_idle();
    return model_run() && (m_pre == m_mode[15:8]) && (m_cnt == m_cmp);
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_step(input logic we, input logic [1:0] a, input logic [15:0] d);
    logic cfg, run, tick, match, fall;
    cfg   = we && (a < 2'd2);
    run   = model_run();
    tick  = run && !cfg && (m_pre == m_mode[15:8]);
    match = tick && (m_cnt == m_cmp);
    fall  = we && (a == 2'd0) && m_mode[0] && !d[0];
    m_pre = (!run || cfg || tick) ? 8'd0 : m_pre + 8'd1;
    if (fall)                      m_cnt = 16'd0;
    else if (we && a == 2'd2)      m_cnt = d;
    else if (match && m_mode[3])   m_cnt = 16'd0;
    else if (tick)                 m_cnt = m_cnt + 16'd1;
    if (fall)                      m_evt = 1'b0;
    else if (match)                m_evt = 1'b1;
    else if (we && a == 2'd3 && d[0]) m_evt = 1'b0;
    if (we && a == 2'd0) m_mode = d;
    if (we && a == 2'd1) m_cmp  = d;
  endtask

  // one bus cycle, driven and checked on the falling edge
  task automatic cyc(input logic we, input logic [1:0] a, input logic [15:0] d, input string tag);
    bus_we = we; bus_addr = a; bus_wdata = d;
    #0.5;
    if (!we) chk(tag, bus_rdata, exp_read(a));
    chk("R7 irq", {15'd0, irq_o}, {15'd0, m_mode[4] && m_evt});
    model_step(we, a, d);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 16'd0, tag);
  endtask

  initial begin
    #900000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int r;
    void'($urandom(32'd4711));
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = 16'd0;
    m_mode = 0; m_cmp = 0; m_cnt = 0; m_pre = 0; m_evt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int a = 0; a < 4; a++) cyc(1'b0, 2'(a), 16'd0, "R1 reset");

    // R2: slowest divider, then fastest
    cyc(1'b1, 2'd1, 16'hFFFF, "R2");
    cyc(1'b1, 2'd0, 16'hFF03, "R2");
    cyc(1'b1, 2'd2, 16'd0, "R2");
    idle(256 * 3, "R2");
    cyc(1'b0, 2'd2, 16'd0, "R2 slow count");
    cyc(1'b1, 2'd0, 16'h0003, "R10");
    idle(5, "R2");
    cyc(1'b0, 2'd2, 16'd0, "R2 fast count");

    // R3: other source codes hold the count
    cyc(1'b1, 2'd0, 16'h0005, "R3");
    idle(6, "R3");
    cyc(1'b0, 2'd2, 16'd0, "R3 held");
    cyc(1'b1, 2'd0, 16'h0007, "R3");
    idle(6, "R3");
    cyc(1'b0, 2'd2, 16'd0, "R3 held");

    // R4: enable low holds the count
    cyc(1'b1, 2'd0, 16'h0002, "R4");
    idle(6, "R4");
    cyc(1'b0, 2'd2, 16'd0, "R4 held");

    // R6/R9: restart on match, clear colliding with a match
    cyc(1'b1, 2'd0, 16'h001B, "R6");
    cyc(1'b1, 2'd1, 16'd4, "R6");
    cyc(1'b1, 2'd2, 16'd0, "R6");
    for (int g = 0; g < 50 && !match_if_idle(); g++) cyc(1'b0, 2'd2, 16'd0, "R6 count");
    cyc(1'b1, 2'd3, 16'h0001, "R9");
    cyc(1'b0, 2'd3, 16'd0, "R9 match wins");
    cyc(1'b0, 2'd2, 16'd0, "R6 restart");
    cyc(1'b1, 2'd3, 16'hFFFE, "R9");
    cyc(1'b0, 2'd3, 16'd0, "R9 zero write keeps flag");
    cyc(1'b0, 2'd0, 16'd0, "R7");

    // R5: falling enable clears count and flag
    cyc(1'b1, 2'd0, 16'h001A, "R5");
    cyc(1'b0, 2'd2, 16'd0, "R5 count");
    cyc(1'b0, 2'd3, 16'd0, "R5 flag");

    // R6: rollover without restart
    cyc(1'b1, 2'd0, 16'h0003, "R6");
    cyc(1'b1, 2'd1, 16'd5, "R6");
    cyc(1'b1, 2'd2, 16'hFFFE, "R8");
    idle(3, "R6");
    cyc(1'b0, 2'd2, 16'd0, "R6 wrap");
    cyc(1'b1, 2'd3, 16'h0001, "R9");
    cyc(1'b0, 2'd3, 16'd0, "R9 cleared");

    // random mix
    for (int i = 0; i < 8000; i++) begin
      r = $urandom % 100;
      if (r < 55) begin
        cyc(1'b0, 2'($urandom % 4), 16'd0, "R8 read");
      end else if (r < 63) begin
        d = 16'($urandom);
        d[15:8] = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 3);
        d[0]    = ($urandom % 8) != 0;
        d[2:1]  = ($urandom % 3 == 0) ? 2'($urandom) : 2'b01;
        cyc(1'b1, 2'd0, d, "R10 mode");
      end else if (r < 70) begin
        d = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 20);
        cyc(1'b1, 2'd1, d, "R10 cmp");
      end else if (r < 76) begin
        d = ($urandom % 3 == 0) ? 16'hFFF0 + 16'($urandom % 16) : 16'($urandom % 20);
        cyc(1'b1, 2'd2, d, "R8 load");
      end else if (r < 86) begin
        cyc(1'b1, 2'd3, 16'($urandom), "R9 w1c");
      end else begin
        cyc(1'b0, 2'd3, 16'd0, "R6 event");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule